// File: doc/BRIEF.md
# Video Timing-Reference Lock Detector

This block watches the word stream of a received serial-digital video link and decides whether its line timing is stable. Each incoming word comes with a valid strobe and two one-word detect pulses, one for the end-of-active-video mark (EAV) and one for the start-of-active-video mark (SAV). A word counter gives every valid word a position within its line. EAV starts a new line and marks position 0. The block records where each EAV and SAV falls. When the same timing repeats for `LOCK_LINES` lines in a row, it raises a lock flag.

Once locked, the block predicts where the next marks are due. A mark that does not come on time counts as a miss, and so does a mark that comes at the wrong position. For a missing EAV, the counter restarts the line as though the EAV had come on time. Up to `MISS_TOL` consecutive misses leave the lock in place. One miss beyond that drops the lock, and the block hunts again. The lock decision is a four-state machine:

- **HUNT**: waits for any EAV to fix the start of a line.
- **MEASURE**: records one full line as the first reference.
- **TRACK**: counts consecutive lines that match the reference.
- **LOCKED**: polices timing marks against the reference.

The transitions are:

- **hunt-to-measure**: on any EAV.
- **measure-to-track**: on an EAV that ends a line which contained an SAV.
- **track-reload**: a mismatching line that contained an SAV becomes the new reference, and the match count returns to 1.
- **track-to-measure**: on a line with no SAV.
- **track-to-locked**: when the match count reaches `LOCK_LINES`.
- **locked-to-hunt**: on the miss that exceeds the tolerance.

Top module: `vtl_trs_lock_det`

## Requirements
- R1: While reset is high, and in the cycle after, `trs_locked`, `eav_pos` and `sav_pos` are all 0.
- R2: Only words with `word_vld` high are counted. A word carrying an EAV is position 0, and the next valid word is position 1. On each EAV, `eav_pos` is loaded with the count of valid words since the previous EAV, one cycle after that word. On the first SAV of a line, `sav_pos` is loaded with that SAV's position, also one cycle later. Pulses on invalid words have no effect.
- R3: `trs_locked` rises one cycle after the EAV that completes `LOCK_LINES` (6) consecutive lines with identical EAV and SAV positions. The first full line after the first EAV counts as line 1.
- R4: Before lock, a line whose EAV or SAV position differs from the reference becomes the new reference, and the match count restarts at 1. A line with no SAV sends the block back to measuring.
- R5: An SAV on the same word as an EAV is ignored. So are SAV pulses after the first one in a line; `sav_pos` keeps the first.
- R6: While locked, reaching position reference-EAV+1 without an EAV is a miss. That word becomes position 1 of a new line, so an SAV at the reference position still counts as on time.
- R7: While locked, each of these is a miss: reaching position reference-SAV+1 with no SAV yet in the line, an EAV at a position other than the reference, and a first SAV at a position other than the reference.
- R8: With `MISS_TOL` = 4, four consecutive misses keep `trs_locked` high. The fifth drops it one cycle after the word that produced it.
- R9: An EAV or SAV at its expected position resets the consecutive-miss count to zero.
- R10: After lock is lost, relocking needs a fresh EAV followed by `LOCK_LINES` matching lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Current word is valid |
| eav_in | input | 1 | End-of-active-video mark on current word |
| sav_in | input | 1 | Start-of-active-video mark on current word |
| trs_locked | output | 1 | Line timing is stable |
| eav_pos | output | CW | Last measured EAV position (line length in words) |
| sav_pos | output | CW | Last measured SAV position from line start |

## Verification
All three outputs are registered directly from the word sampled at a clock edge. A position update, a lock rise or a lock drop is therefore due in the cycle after the word that causes it. The bench drives each word on a falling edge and lets one rising edge pass. It then compares every output at the next falling edge against a reference model, which it advances on that same rising edge. The directed checks on lock rise and drop sit on the word that completes the sixth matching line or produces the fifth miss. Random lines with dropped marks, displaced marks and idle gaps then exercise the same cycle-exact comparison.

// File: rtl/vtl_pkg.sv
package vtl_pkg;

    // Lock decision states
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_TRACK   = 2'd2,
        ST_LOCKED  = 2'd3
    } lock_st_e;

endpackage

// File: rtl/vtl_word_ctr.sv
// Word position counter with per-line SAV capture and measured-position outputs.
module vtl_word_ctr #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          word_vld,
    input  logic          eav_in,
    input  logic          sav_in,
    input  logic          realign,
    output logic [CW-1:0] pos,
    output logic [CW-1:0] line_sav,
    output logic          sav_seen,
    output logic          eav_evt,
    output logic          sav_evt,
    output logic [CW-1:0] eav_pos,
    output logic [CW-1:0] sav_pos
);

    localparam logic [CW-1:0] POS_ONE = CW'(1);
    localparam logic [CW-1:0] POS_TWO = CW'(2);

    // EAV wins over SAV on a shared word; only the first SAV in a line counts.
    assign eav_evt = word_vld & eav_in;
    assign sav_evt = word_vld & sav_in & ~eav_in & ~realign & ~sav_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            line_sav <= '0;
            sav_seen <= 1'b0;
            eav_pos  <= '0;
            sav_pos  <= '0;
        end else if (word_vld) begin
            if (eav_in) begin
                eav_pos  <= pos;
                pos      <= POS_ONE;
                sav_seen <= 1'b0;
            end else if (realign) begin
                // This word is position 1 of a line whose EAV went missing.
                pos      <= POS_TWO;
                sav_seen <= 1'b0;
            end else begin
                pos <= pos + POS_ONE;
                if (sav_evt) begin
                    sav_seen <= 1'b1;
                    line_sav <= pos;
                    sav_pos  <= pos;
                end
            end
        end
    end

endmodule

// File: rtl/vtl_mark_cmp.sv
// Compares current marks and positions against the stored reference timing.
module vtl_mark_cmp #(
    parameter int CW = 12
) (
    input  logic          word_vld,
    input  logic          eav_in,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] ref_eav,
    input  logic [CW-1:0] ref_sav,
    input  logic [CW-1:0] line_sav,
    input  logic          sav_seen,
    input  logic          eav_evt,
    input  logic          sav_evt,
    output logic          eav_late,
    output logic          line_match,
    output logic          mark_hit,
    output logic          mark_miss
);

    localparam logic [CW-1:0] POS_ONE = CW'(1);

    logic [CW-1:0] eav_due_past;
    logic [CW-1:0] sav_due_past;
    logic          eav_at_ref;
    logic          sav_at_ref;
    logic          sav_late;
    logic          eav_off;
    logic          sav_off;

    assign eav_due_past = ref_eav + POS_ONE;
    assign sav_due_past = ref_sav + POS_ONE;
    assign eav_at_ref   = (pos == ref_eav);
    assign sav_at_ref   = (pos == ref_sav);

    assign eav_late   = word_vld & ~eav_in & (pos == eav_due_past);
    assign sav_late   = word_vld & ~eav_in & ~sav_seen & (pos == sav_due_past);
    assign eav_off    = eav_evt & ~eav_at_ref;
    assign sav_off    = sav_evt & ~sav_at_ref;

    assign mark_hit   = (eav_evt & eav_at_ref) | (sav_evt & sav_at_ref);
    assign mark_miss  = sav_late | eav_off | sav_off;
    assign line_match = eav_evt & eav_at_ref & sav_seen & (line_sav == ref_sav);

endmodule

// File: rtl/vtl_lock_fsm.sv
// Lock decision state machine with reference storage and match/miss counting.
module vtl_lock_fsm
    import vtl_pkg::*;
#(
    parameter int CW         = 12,
    parameter int LOCK_LINES = 6,
    parameter int MISS_TOL   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eav_evt,
    input  logic          sav_seen,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] line_sav,
    input  logic          line_match,
    input  logic          eav_late,
    input  logic          mark_hit,
    input  logic          mark_miss,
    output lock_st_e      state_q,
    output logic [CW-1:0] ref_eav,
    output logic [CW-1:0] ref_sav,
    output logic          realign,
    output logic          trs_locked
);

    localparam int MW = $clog2(LOCK_LINES + 1);
    localparam int XW = $clog2(MISS_TOL + 2);
    localparam logic [MW-1:0] MATCH_ONE  = MW'(1);
    localparam logic [MW-1:0] MATCH_LAST = MW'(LOCK_LINES - 1);
    localparam logic [XW-1:0] MISS_ONE   = XW'(1);
    localparam logic [XW-1:0] MISS_LAST  = XW'(MISS_TOL);

    lock_st_e      state_d;
    logic [MW-1:0] match_q, match_d;
    logic [XW-1:0] miss_q, miss_d;
    logic          load_ref;
    logic          miss_any;

    assign realign  = (state_q == ST_LOCKED) & eav_late;
    assign miss_any = realign | mark_miss;

    always_comb begin
        state_d  = state_q;
        match_d  = match_q;
        miss_d   = miss_q;
        load_ref = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (eav_evt) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (eav_evt && sav_seen) begin
                    load_ref = 1'b1;
                    match_d  = MATCH_ONE;
                    state_d  = ST_TRACK;
                end
            end
            ST_TRACK: begin
                if (eav_evt) begin
                    if (line_match) begin
                        if (match_q == MATCH_LAST) begin
                            state_d = ST_LOCKED;
                            match_d = '0;
                            miss_d  = '0;
                        end else begin
                            match_d = match_q + MATCH_ONE;
                        end
                    end else if (sav_seen) begin
                        load_ref = 1'b1;
                        match_d  = MATCH_ONE;
                    end else begin
                        state_d = ST_MEASURE;
                        match_d = '0;
                    end
                end
            end
            ST_LOCKED: begin
                if (mark_hit) begin
                    miss_d = '0;
                end else if (miss_any) begin
                    if (miss_q == MISS_LAST) begin
                        state_d = ST_HUNT;
                        miss_d  = '0;
                    end else begin
                        miss_d = miss_q + MISS_ONE;
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    // Counters and reference timing
    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            miss_q  <= '0;
            ref_eav <= '0;
            ref_sav <= '0;
        end else begin
            match_q <= match_d;
            miss_q  <= miss_d;
            if (load_ref) begin
                ref_eav <= pos;
                ref_sav <= line_sav;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) trs_locked <= 1'b0;
        else     trs_locked <= (state_d == ST_LOCKED);
    end

endmodule

// File: rtl/vtl_trs_lock_det.sv
// Top level: timing-reference lock detector.
module vtl_trs_lock_det
    import vtl_pkg::*;
#(
    parameter int CW         = 12,
    parameter int LOCK_LINES = 6,
    parameter int MISS_TOL   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          word_vld,
    input  logic          eav_in,
    input  logic          sav_in,
    output logic          trs_locked,
    output logic [CW-1:0] eav_pos,
    output logic [CW-1:0] sav_pos
);

    lock_st_e      state_q;
    logic [CW-1:0] pos;
    logic [CW-1:0] line_sav;
    logic [CW-1:0] ref_eav;
    logic [CW-1:0] ref_sav;
    logic          sav_seen;
    logic          eav_evt;
    logic          sav_evt;
    logic          realign;
    logic          eav_late;
    logic          line_match;
    logic          mark_hit;
    logic          mark_miss;

    vtl_word_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .eav_in   (eav_in),
        .sav_in   (sav_in),
        .realign  (realign),
        .pos      (pos),
        .line_sav (line_sav),
        .sav_seen (sav_seen),
        .eav_evt  (eav_evt),
        .sav_evt  (sav_evt),
        .eav_pos  (eav_pos),
        .sav_pos  (sav_pos)
    );

    vtl_mark_cmp #(.CW(CW)) u_cmp (
        .word_vld   (word_vld),
        .eav_in     (eav_in),
        .pos        (pos),
        .ref_eav    (ref_eav),
        .ref_sav    (ref_sav),
        .line_sav   (line_sav),
        .sav_seen   (sav_seen),
        .eav_evt    (eav_evt),
        .sav_evt    (sav_evt),
        .eav_late   (eav_late),
        .line_match (line_match),
        .mark_hit   (mark_hit),
        .mark_miss  (mark_miss)
    );

    vtl_lock_fsm #(
        .CW         (CW),
        .LOCK_LINES (LOCK_LINES),
        .MISS_TOL   (MISS_TOL)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .eav_evt    (eav_evt),
        .sav_seen   (sav_seen),
        .pos        (pos),
        .line_sav   (line_sav),
        .line_match (line_match),
        .eav_late   (eav_late),
        .mark_hit   (mark_hit),
        .mark_miss  (mark_miss),
        .state_q    (state_q),
        .ref_eav    (ref_eav),
        .ref_sav    (ref_sav),
        .realign    (realign),
        .trs_locked (trs_locked)
    );

endmodule

// File: rtl/vtl_lock_chk.sv
// Property checker, attached to the top module by bind.
module vtl_lock_chk
    import vtl_pkg::*;
#(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          word_vld,
    input logic          eav_in,
    input logic          trs_locked,
    input logic [CW-1:0] eav_pos,
    input logic [CW-1:0] sav_pos,
    input lock_st_e      state_q
);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!trs_locked && eav_pos == '0 && sav_pos == '0));

    a_r2_idle_no_change: assert property (@(posedge clk) disable iff (rst)
        !word_vld |=> ($stable(eav_pos) && $stable(sav_pos) && $stable(trs_locked)));

    a_r3_lock_on_eav: assert property (@(posedge clk) disable iff (rst)
        $rose(trs_locked) |-> $past(word_vld && eav_in));

    a_r8_drop_on_word: assert property (@(posedge clk) disable iff (rst)
        ($fell(trs_locked) && !$past(rst)) |-> $past(word_vld));

    a_r4_track_entry: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRACK && $past(state_q) != ST_TRACK && !$past(rst))
        |-> ($past(state_q) == ST_MEASURE && $past(word_vld && eav_in)));

    a_r10_exit_to_hunt: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_LOCKED && state_q != ST_LOCKED && !$past(rst))
        |-> state_q == ST_HUNT);

endmodule

bind vtl_trs_lock_det vtl_lock_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_vld   (word_vld),
    .eav_in     (eav_in),
    .trs_locked (trs_locked),
    .eav_pos    (eav_pos),
    .sav_pos    (sav_pos),
    .state_q    (state_q)
);

// File: tb/tb_vtl_trs_lock_det.sv
`timescale 1ns/1ps
module tb_vtl_trs_lock_det;

    localparam int CW         = 12;
    localparam int LOCK_LINES = 6;
    localparam int MISS_TOL   = 4;
    localparam int LMASK      = (1 << CW) - 1;
    localparam int M_HUNT = 0, M_MEAS = 1, M_TRACK = 2, M_LOCK = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          word_vld;
    logic          eav_in;
    logic          sav_in;
    logic          trs_locked;
    logic [CW-1:0] eav_pos;
    logic [CW-1:0] sav_pos;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    // Reference model state
    int m_st, m_cnt, m_seen, m_lsav, m_epos, m_spos, m_reav, m_rsav, m_match, m_miss, m_lock;

    vtl_trs_lock_det #(.CW(CW), .LOCK_LINES(LOCK_LINES), .MISS_TOL(MISS_TOL)) dut (
        .clk(clk), .rst(rst), .word_vld(word_vld), .eav_in(eav_in), .sav_in(sav_in),
        .trs_locked(trs_locked), .eav_pos(eav_pos), .sav_pos(sav_pos)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_st = M_HUNT; m_cnt = 0; m_seen = 0; m_lsav = 0; m_epos = 0; m_spos = 0;
        m_reav = 0; m_rsav = 0; m_match = 0; m_miss = 0; m_lock = 0;
    endtask

    // Advances the model by one sampled word, following R2..R10.
    task automatic m_step(bit v, bit e, bit s);
        int c, ph, se, sl, hit, miss, lm;
        if (!v) return;
        c   = m_cnt;
        ph  = (m_st == M_LOCK) && !e && (c == ((m_reav + 1) & LMASK));
        se  = s && !e && !ph && !m_seen;
        sl  = !e && !m_seen && (c == ((m_rsav + 1) & LMASK));
        hit = (e && c == m_reav) || (se && c == m_rsav);
        miss = ph || sl || (e && c != m_reav) || (se && c != m_rsav);
        lm  = e && c == m_reav && m_seen && m_lsav == m_rsav;
        case (m_st)
            M_HUNT: if (e) m_st = M_MEAS;
            M_MEAS: if (e && m_seen) begin m_reav = c; m_rsav = m_lsav; m_match = 1; m_st = M_TRACK; end
            M_TRACK: if (e) begin
                if (lm) begin
                    if (m_match == LOCK_LINES - 1) begin m_st = M_LOCK; m_match = 0; m_miss = 0; end
                    else m_match++;
                end else if (m_seen) begin m_reav = c; m_rsav = m_lsav; m_match = 1; end
                else begin m_st = M_MEAS; m_match = 0; end
            end
            default: begin
                if (hit) m_miss = 0;
                else if (miss) begin
                    if (m_miss == MISS_TOL) begin m_st = M_HUNT; m_miss = 0; end
                    else m_miss++;
                end
            end
        endcase
        m_lock = (m_st == M_LOCK);
        if (e) begin m_epos = c; m_cnt = 1; m_seen = 0; end
        else if (ph) begin m_cnt = 2; m_seen = 0; end
        else begin
            m_cnt = (c + 1) & LMASK;
            if (se) begin m_seen = 1; m_lsav = c; m_spos = c; end
        end
    endtask

    // Drives one word at a falling edge, checks all outputs one cycle later.
    task automatic word(bit v, bit e, bit s);
        word_vld = v; eav_in = e; sav_in = s;
        @(posedge clk);
        m_step(v, e, s);
        @(negedge clk);
        chk("R2 eav_pos", int'(eav_pos), m_epos);
        chk("R2 sav_pos", int'(sav_pos), m_spos);
        chk("R3 R8 trs_locked", int'(trs_locked), m_lock);
    endtask

    task automatic line(int len, int sp, bit de, bit ds, int gap_pct, int from);
        for (int p = from; p < len; p++) begin
            if (gap_pct > 0 && ($urandom % 100) < gap_pct)
                word(1'b0, 1'($urandom % 2), 1'($urandom % 2));
            word(1'b1, de && p == 0, ds && p == sp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected completion before %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        rst = 1'b1; word_vld = 1'b0; eav_in = 1'b0; sav_in = 1'b0;
        m_reset();
        repeat (3) @(negedge clk);
        chk("R1 trs_locked", int'(trs_locked), 0);
        chk("R1 eav_pos", int'(eav_pos), 0);
        chk("R1 sav_pos", int'(sav_pos), 0);
        rst = 1'b0;
        word(1'b0, 1'b1, 1'b1);
        chk("R1 idle after reset", int'(eav_pos), 0);

        // R3: six lines after the first EAV, lock on the next EAV
        repeat (6) line(20, 4, 1, 1, 0, 0);
        chk("R3 not yet locked", int'(trs_locked), 0);
        word(1'b1, 1'b1, 1'b0);
        chk("R3 locked on seventh EAV", int'(trs_locked), 1);
        chk("R2 line length", int'(eav_pos), 20);
        line(20, 4, 1, 1, 0, 1);
        chk("R2 sav position", int'(sav_pos), 4);

        // R5: SAV with EAV and a second SAV are ignored
        for (int p = 0; p < 20; p++) word(1'b1, p == 0, p == 0 || p == 4 || p == 9);
        chk("R5 first sav kept", int'(sav_pos), 4);
        chk("R5 lock held", int'(trs_locked), 1);

        // R6: missing EAV, realigned line keeps SAV on time
        line(20, 4, 0, 1, 0, 0);
        chk("R6 lock held", int'(trs_locked), 1);
        chk("R6 eav_pos unchanged", int'(eav_pos), 20);
        chk("R6 sav at realigned pos", int'(sav_pos), 4);
        line(20, 4, 1, 1, 0, 0);

        // R8/R9: four misses held, hit clears, fifth miss drops
        repeat (2) line(20, 4, 0, 0, 0, 0);
        chk("R8 four misses held", int'(trs_locked), 1);
        line(20, 4, 1, 1, 0, 0);
        repeat (2) line(20, 4, 0, 0, 0, 0);
        chk("R9 count cleared by hit", int'(trs_locked), 1);
        word(1'b1, 1'b0, 1'b0);
        chk("R8 no fifth miss yet", int'(trs_locked), 1);
        word(1'b1, 1'b0, 1'b0);
        chk("R8 fifth miss drops", int'(trs_locked), 0);
        line(20, 4, 0, 0, 0, 2);

        // R10: relock needs EAV plus six lines
        repeat (6) line(20, 4, 1, 1, 0, 0);
        chk("R10 not relocked", int'(trs_locked), 0);
        line(20, 4, 1, 1, 0, 0);
        chk("R10 relocked", int'(trs_locked), 1);

        // R7: displaced SAV counts as miss (3 + 2 = 5 misses)
        line(20, 4, 0, 0, 0, 0);
        line(20, 7, 0, 1, 0, 0);
        chk("R7 displaced sav miss drops", int'(trs_locked), 0);

        // R4: mismatch before lock restarts count
        repeat (4) line(20, 4, 1, 1, 0, 0);
        repeat (6) line(24, 4, 1, 1, 0, 0);
        chk("R4 restart delays lock", int'(trs_locked), 0);
        word(1'b1, 1'b1, 1'b0);
        chk("R4 lock after restart", int'(trs_locked), 1);
        line(24, 4, 1, 1, 0, 1);

        // Random lines with drops, displacement and gaps
        for (int i = 0; i < 300; i++) begin
            line((($urandom % 8) == 0) ? 22 : 20, (($urandom % 8) == 0) ? 6 : 4,
                 ($urandom % 10) != 0, ($urandom % 10) != 0, 10, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule